// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This unit carries out one sized memory access at a time over a bus whose data path is one word wide. A request names a direction (load or store), a size code and a 12-bit signed displacement. The unit adds the sign-extended displacement to a base value to form the bus address. On a load it cuts the returned word down to a byte, a halfword or the full word and extends it to full width. The extension is signed or unsigned, depending on the size code.

A store does not use per-byte write strobes. The unit reads the word currently on the bus at the target address, keeps its bytes outside a size mask, and puts the register bytes inside the mask. It then drives the combined word with a write enable that lasts one cycle. The mask always covers the low end of the word, and the low address bits do not move it. Aligned access is the caller's job.

The request comes straight from the instruction fields. The unit builds the displacement from those fields in the layout that fits the direction. Once the access is over it raises a completion pulse for one cycle.

Top module: `lsu_unit`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted request, bus_addr_o, bus_wdata_o and load_data_o are zero, and bus_we_o and done_o are low.
- R2: A request is taken when start_i is high at a clock edge while the unit is idle. From the next cycle until the done cycle, bus_addr_o equals base_i plus the sign-extended 12-bit displacement. For a load the displacement is {fld_hi_i, fld_mid_i}.
- R3: For a store the displacement is {fld_hi_i, fld_lo_i}. fld_hi_i carries displacement bits 11:5, and fld_lo_i carries bits 4:0.
- R4: A load is opcode_i = 7'b0000011. funct3_i values 3'b000, 3'b001 and 3'b010 return bits 7:0, bits 15:0 or bits 31:0 of bus_rdata_i, sign-extended to 32 bits. The result appears on load_data_o two cycles after the accepting edge and is held until the next load.
- R5: For a load, funct3_i 3'b100 returns bits 7:0 and 3'b101 returns bits 15:0 of bus_rdata_i, zero-extended.
- R6: A store is opcode_i = 7'b0100011, with funct3_i 3'b000, 3'b001 or 3'b010 selecting mask 0x000000FF, 0x0000FFFF or 0xFFFFFFFF. Two cycles after the accepting edge, bus_we_o is high for exactly one cycle. In that cycle bus_wdata_o is (store_data_i & mask) | (bus_rdata_i at the target & ~mask).
- R7: done_o is high for exactly one cycle, three cycles after the accepting edge. This is the cycle after the load result appears or after the write cycle. bus_we_o is low in that cycle.
- R8: A start_i with any other opcode, or with a funct3_i outside the listed values for its direction, is ignored. No write, no done pulse, and no change to load_data_o follow.
- R9: start_i is ignored from the accepting edge through the done cycle. A request held during that window causes no write and no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| opcode_i | input | 7 | Major opcode of the request |
| funct3_i | input | 3 | Size and extension code |
| fld_hi_i | input | 7 | Displacement bits 11:5 |
| fld_mid_i | input | 5 | Load displacement bits 4:0 |
| fld_lo_i | input | 5 | Store displacement bits 4:0 |
| base_i | input | 32 | Base address value |
| store_data_i | input | 32 | Register data to store |
| bus_rdata_i | input | 32 | Word read at bus_addr_o |
| bus_addr_o | output | 32 | Bus address |
| bus_wdata_o | output | 32 | Merged write word |
| bus_we_o | output | 1 | Write enable, one cycle per store |
| load_data_o | output | 32 | Extended load result |
| done_o | output | 1 | Completion pulse |

## Verification
The assertions assume that bus_rdata_i reflects bus_addr_o within the same cycle, with no wait states. They also assume that the write enable is only ever produced by an accepted store, so that each write is followed by the done pulse. The bench meets the first assumption with a small word array read combinationally through address bits 5:2 and written on the clock edge. It drives requests only at falling edges, holding each one for one cycle, except in the deliberate R9 case where a request is held across a busy access. Sign-sensitive words (top bit of the byte and of the halfword set and clear) are placed at every slot before the size and displacement sweeps.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned ILEN_OPC = 7;
  localparam logic [ILEN_OPC-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [ILEN_OPC-1:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_FIN,
    ST_DONE
  } lsu_state_e;

  function automatic logic load_code_ok(input logic [2:0] f3);
    return (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010) ||
           (f3 == 3'b100) || (f3 == 3'b101);
  endfunction

  function automatic logic store_code_ok(input logic [2:0] f3);
    return (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010);
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 12
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] disp_i,
  output logic [XLEN-1:0]  addr_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] disp_sx;
  assign disp_sx = {{EXT_W{disp_i[IMM_W-1]}}, disp_i};
  assign addr_o  = base_i + disp_sx;
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      funct3_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] result_o
);
  localparam int unsigned B_W = 8;
  localparam int unsigned H_W = 16;

  logic sx_b, sx_h;
  size_e sz;

  assign sz   = size_e'(funct3_i[1:0]);
  // funct3[2] set selects zero extension
  assign sx_b = ~funct3_i[2] & rdata_i[B_W-1];
  assign sx_h = ~funct3_i[2] & rdata_i[H_W-1];

  always_comb begin
    unique case (sz)
      SZ_BYTE: result_o = {{(XLEN-B_W){sx_b}}, rdata_i[B_W-1:0]};
      SZ_HALF: result_o = {{(XLEN-H_W){sx_h}}, rdata_i[H_W-1:0]};
      default: result_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_store_merge.sv
module lsu_store_merge
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] new_i,
  input  logic [XLEN-1:0] old_i,
  output logic [XLEN-1:0] merged_o
);
  localparam int unsigned NLANE = XLEN / 8;

  logic [NLANE-1:0] lane_on;
  logic [XLEN-1:0]  mask;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    if (b == 0) begin : g_b0
      assign lane_on[b] = 1'b1;
    end else if (b == 1) begin : g_b1
      assign lane_on[b] = (size_i != SZ_BYTE);
    end else begin : g_bn
      assign lane_on[b] = (size_i == SZ_WORD);
    end
    assign mask[b*8 +: 8] = {8{lane_on[b]}};
  end

  assign merged_o = (new_i & mask) | (old_i & ~mask);
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic req_ok_i,
  output logic cap_o,
  output logic acc_o,
  output logic done_o
);
  lsu_state_e state_q, state_d;

  assign cap_o  = (state_q == ST_IDLE) & start_i & req_ok_i;
  assign acc_o  = (state_q == ST_ACC);
  assign done_o = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cap_o) state_d = ST_ACC;
      ST_ACC:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [6:0]      opcode_i,
  input  logic [2:0]      funct3_i,
  input  logic [6:0]      fld_hi_i,
  input  logic [4:0]      fld_mid_i,
  input  logic [4:0]      fld_lo_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] store_data_i,
  input  logic [XLEN-1:0] bus_rdata_i,
  output logic [XLEN-1:0] bus_addr_o,
  output logic [XLEN-1:0] bus_wdata_o,
  output logic            bus_we_o,
  output logic [XLEN-1:0] load_data_o,
  output logic            done_o
);
  logic             is_ld, is_st, req_ok;
  logic [IMM_W-1:0] disp;
  logic [XLEN-1:0]  ea, ld_fmt, st_merged;
  logic             cap, acc;

  logic [XLEN-1:0]  addr_q, sdata_q, wdata_q, ld_q;
  logic [2:0]       f3_q;
  logic             st_q, we_q;

  assign is_ld  = (opcode_i == OPC_LOAD);
  assign is_st  = (opcode_i == OPC_STORE);
  assign req_ok = (is_ld & load_code_ok(funct3_i)) |
                  (is_st & store_code_ok(funct3_i));
  // displacement low bits sit in different fields per direction
  assign disp   = is_st ? {fld_hi_i, fld_lo_i} : {fld_hi_i, fld_mid_i};

  lsu_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .base_i (base_i),
    .disp_i (disp),
    .addr_o (ea)
  );

  lsu_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .req_ok_i (req_ok),
    .cap_o    (cap),
    .acc_o    (acc),
    .done_o   (done_o)
  );

  lsu_load_fmt #(.XLEN(XLEN)) u_ldfmt (
    .funct3_i (f3_q),
    .rdata_i  (bus_rdata_i),
    .result_o (ld_fmt)
  );

  lsu_store_merge #(.XLEN(XLEN)) u_merge (
    .size_i   (f3_q[1:0]),
    .new_i    (sdata_q),
    .old_i    (bus_rdata_i),
    .merged_o (st_merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      sdata_q <= '0;
      f3_q    <= '0;
      st_q    <= 1'b0;
    end else if (cap) begin
      addr_q  <= ea;
      sdata_q <= store_data_i;
      f3_q    <= funct3_i;
      st_q    <= is_st;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      ld_q    <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= acc & st_q;
      if (acc && st_q)  wdata_q <= st_merged;
      if (acc && !st_q) ld_q    <= ld_fmt;
    end
  end

  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_we_o    = we_q;
  assign load_data_o = ld_q;
endmodule

// File: rtl/lsu_unit_chk.sv
module lsu_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bus_we_o,
  input logic            done_o,
  input logic [XLEN-1:0] bus_addr_o
);
  a_r6_we_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o);

  a_r7_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> done_o);

  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_no_we_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && done_o));

  a_r2_addr_held_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> $stable(bus_addr_o));

  a_r9_no_write_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !bus_we_o);
endmodule

bind lsu_unit lsu_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_o   (bus_we_o),
  .done_o     (done_o),
  .bus_addr_o (bus_addr_o)
);

// File: tb/lsu_unit_tb.sv
module lsu_unit_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  opcode_i = '0;
  logic [2:0]  funct3_i = '0;
  logic [6:0]  fld_hi_i = '0;
  logic [4:0]  fld_mid_i = '0;
  logic [4:0]  fld_lo_i = '0;
  logic [31:0] base_i = '0;
  logic [31:0] store_data_i = '0;
  logic [31:0] bus_rdata_i;
  logic [31:0] bus_addr_o, bus_wdata_o, load_data_o;
  logic        bus_we_o, done_o;

  logic [31:0] mem [16];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  assign bus_rdata_i = mem[bus_addr_o[5:2]];
  always @(posedge clk_i) if (bus_we_o) mem[bus_addr_o[5:2]] <= bus_wdata_o;

  lsu_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
    .funct3_i(funct3_i), .fld_hi_i(fld_hi_i), .fld_mid_i(fld_mid_i),
    .fld_lo_i(fld_lo_i), .base_i(base_i), .store_data_i(store_data_i),
    .bus_rdata_i(bus_rdata_i), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_we_o(bus_we_o), .load_data_o(load_data_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [31:0] exp_load(input logic [2:0] f3, input logic [31:0] w);
    case (f3)
      3'b000:  return {{24{w[7]}}, w[7:0]};
      3'b001:  return {{16{w[15]}}, w[15:0]};
      3'b100:  return {24'd0, w[7:0]};
      3'b101:  return {16'd0, w[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] exp_mask(input logic [2:0] f3);
    case (f3)
      3'b000:  return 32'h0000_00FF;
      3'b001:  return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic drive(input logic [6:0] opc, input logic [2:0] f3, input logic [11:0] imm,
                       input logic [31:0] base, input logic [31:0] sd);
    opcode_i = opc; funct3_i = f3; base_i = base; store_data_i = sd;
    fld_hi_i = imm[11:5];
    if (opc == 7'b0100011) begin
      fld_lo_i = imm[4:0]; fld_mid_i = ~imm[4:0];
    end else begin
      fld_mid_i = imm[4:0]; fld_lo_i = ~imm[4:0];
    end
  endtask

  task automatic access(input bit st, input logic [2:0] f3, input logic [11:0] imm,
                        input logic [31:0] base, input logic [31:0] sd);
    logic [31:0] ea, old, expw;
    logic [3:0]  idx;
    ea   = base + {{20{imm[11]}}, imm};
    idx  = ea[5:2];
    old  = mem[idx];
    expw = (sd & exp_mask(f3)) | (old & ~exp_mask(f3));
    @(negedge clk_i);
    drive(st ? 7'b0100011 : 7'b0000011, f3, imm, base, sd);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(bus_addr_o == ea, st ? "R3 store address" : "R2 load address", bus_addr_o, ea);
    @(negedge clk_i);
    if (st) begin
      chk(bus_we_o == 1'b1, "R6 write pulse", 32'(bus_we_o), 1);
      chk(bus_wdata_o == expw, "R6 merged data", bus_wdata_o, expw);
    end else begin
      chk(load_data_o == exp_load(f3, old), f3[2] ? "R5 zero-extended load" : "R4 sign-extended load",
          load_data_o, exp_load(f3, old));
      chk(bus_we_o == 1'b0, "R4 no write on load", 32'(bus_we_o), 0);
    end
    chk(done_o == 1'b0, "R7 done not early", 32'(done_o), 0);
    @(negedge clk_i);
    chk(done_o == 1'b1 && bus_we_o == 1'b0, "R7 done pulse", {bus_we_o, done_o}, 32'b01);
    if (st) chk(mem[idx] == expw, "R6 memory word", mem[idx], expw);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done one cycle", 32'(done_o), 0);
  endtask

  task automatic ignored(input logic [6:0] opc, input logic [2:0] f3);
    logic [31:0] ld0;
    int we_n, dn_n;
    ld0 = load_data_o; we_n = 0; dn_n = 0;
    @(negedge clk_i);
    drive(opc, f3, 12'h010, 32'h40, 32'hDEAD_BEEF);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (bus_we_o) we_n++;
      if (done_o) dn_n++;
      @(negedge clk_i);
    end
    chk(we_n == 0 && dn_n == 0 && load_data_o == ld0, "R8 request ignored",
        {we_n[15:0], dn_n[15:0]}, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [31:0] bases [4];
    logic [11:0] imms [5];
    int we_n, dn_n;
    bases[0] = 32'h0000_0000; bases[1] = 32'h0000_1020;
    bases[2] = 32'hFFFF_FFF0; bases[3] = 32'h8000_0804;
    imms[0] = 12'h000; imms[1] = 12'h004; imms[2] = 12'hFFC;
    imms[3] = 12'h7FF; imms[4] = 12'h800;
    for (int i = 0; i < 16; i++)
      mem[i] = (i % 2 == 0) ? (32'h8F80_8080 ^ (i * 32'h0101_0101))
                            : (32'h7F7F_7F7F ^ (i * 32'h1010_0101));

    #(CLK_P * 3);
    @(negedge clk_i);
    chk(bus_addr_o == 0 && bus_wdata_o == 0 && load_data_o == 0 && !bus_we_o && !done_o,
        "R1 reset state", {bus_addr_o[15:0], load_data_o[15:0]}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!bus_we_o && !done_o && bus_addr_o == 0, "R1 idle after release",
        {bus_we_o, done_o}, 0);

    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 5; k++)
        for (int f = 0; f < 8; f++)
          if (f == 0 || f == 1 || f == 2 || f == 4 || f == 5)
            access(1'b0, 3'(f), imms[k], bases[b], 32'h0);

    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 5; k++)
        for (int f = 0; f < 3; f++) begin
          access(1'b1, 3'(f), imms[k], bases[b], 32'hA5C3_9E71 ^ (b * 32'h1111_0000) ^ k);
          access(1'b0, 3'b010, imms[k], bases[b], 32'h0);
        end

    ignored(7'b0110011, 3'b000);
    ignored(7'b0010011, 3'b010);
    ignored(7'b0000011, 3'b011);
    ignored(7'b0000011, 3'b110);
    ignored(7'b0000011, 3'b111);
    ignored(7'b0100011, 3'b011);
    ignored(7'b0100011, 3'b100);
    ignored(7'b0100011, 3'b111);

    // R9: store request held while a load is in flight
    @(negedge clk_i);
    drive(7'b0000011, 3'b010, 12'h008, 32'h0, 32'h0);
    start_i = 1'b1;
    @(negedge clk_i);
    drive(7'b0100011, 3'b000, 12'h008, 32'h0, 32'h1234_5678);
    we_n = 0; dn_n = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      if (bus_we_o) we_n++;
      if (done_o) dn_n++;
    end
    start_i = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      if (bus_we_o) we_n++;
      if (done_o) dn_n++;
    end
    chk(we_n == 0, "R9 no write from held request", we_n, 0);
    chk(dn_n == 1, "R9 single done", dn_n, 1);
    chk(load_data_o == mem[2], "R9 in-flight load result", load_data_o, mem[2]);

    summary();
  end
endmodule